// File: doc/BRIEF.md
# Serial OSD Command Decoder

This block takes 8-bit words from a three-wire serial port and turns them into display-control settings and character writes for an on-screen display. The port has an active-low chip select, a shift clock and a data line. All three are resynchronised into the system clock, and the shift clock is edge-detected there. Commands come in two bytes. A first byte, with bit 7 set, selects a command and carries four data bits. A second byte, with bit 7 clear, carries the rest of the data. The command code is held between bytes, so one first byte can be followed by any number of second bytes.

The character-write command switches the port into a streaming mode. In this mode every later byte in the same chip-select frame is written to the character memory, at a write pointer that advances by itself. Raising chip select ends the frame and returns the held code to the address-setting command. A hardware reset clears every register, and so does a soft-reset bit in the display-control command. Both leave the display off.

Top module: `osd_cmd_decoder`

## Requirements
- R1: Serial bits are sampled on the rising shift-clock edge while `csN` is low, most-significant bit first. Eight edges make one word.
- R2: A word that is only partly shifted when `csN` rises is discarded. The next frame starts at bit 7.
- R3: A byte with bit 7 = 1 loads bits 6..4 as the held code: 000 address, 001 character, 010 vertical, 011 horizontal, 100 display, 101 sync. Every following byte with bit 7 = 0 applies to the held code. Codes 110 and 111 are held, but their second bytes change no output.
- R4: The address command loads the write row from first-byte bits 3..0 and the write column from second-byte bits 4..0.
- R5: After code 001, each byte in the frame, including bytes with bit 7 set, raises `memWe` for one cycle. The byte carries the character code in bits 5..0 and the flash attribute in bit 6, written at the current pointer.
- R6: After each character write, the column increments. Column 23 wraps to 0 and the row increments. Row 9 wraps to row 0.
- R7: A rising `csN` returns the held code to the address command and ends streaming. A write whose last bit lands just before the rise is still completed.
- R8: The vertical command loads `sizeVert` from first-byte bits 3..0: bits 1..0 are the first-row code and bits 3..2 the second-row code. It loads `vStart` from second-byte bits 5..0. The horizontal command loads `sizeHoriz` and `hStart` the same way.
- R9: The display command loads `sysCtrl` from first-byte bits 3..1 (oscillator stop, colour-bar strobe, test). It loads `dispCtrl` from second-byte bits 5..0: bit 0 on, bit 1 inverse, bit 2 blink, bit 3 slow blink, bit 4 border, bit 5 non-interlace.
- R10: The sync command loads `syncCtrl` from first-byte bits 3..0: bit 0 internal sync, bit 1 background, bits 3..2 phase. `detectSel` takes second-byte bits 3..0 only if at most one bit is set; any other value leaves it unchanged.
- R11: A display-command first byte with bit 0 = 1 clears every register and the pointer, and returns the held code to the address command. The byte's other bits are ignored. A low `rstN` does the same.
- R12: After reset, every register output and `memWe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data |
| memWe | output | 1 | Character memory write strobe |
| memRow | output | ROW_W (4) | Write row |
| memCol | output | COL_W (5) | Write column |
| memCode | output | 6 | Character code |
| memFlash | output | 1 | Flash attribute |
| sizeVert | output | 4 | Height codes for the two row groups |
| vStart | output | 6 | Vertical start |
| sizeHoriz | output | 4 | Width codes for the two row groups |
| hStart | output | 6 | Horizontal start |
| sysCtrl | output | 3 | {test, colour-bar strobe, oscillator stop} |
| dispCtrl | output | 6 | Display control flags |
| syncCtrl | output | 4 | {phase[1:0], background, internal sync} |
| detectSel | output | 4 | One-hot sync detection count, 0 = none |

## Verification
The last character byte of a stream and the rise of chip select can be handled in the same clock cycle. The write strobe for that byte leaves the strobe register in the same cycle in which the rise is detected and the held code reverts. The bench provokes this by raising `csN` one system clock after the final shift-clock edge. It then checks that the write still reaches the port at the expected pointer, and that the next frame's lone second byte is taken as a column address and not as a character.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int SIZE_W = 4;
  localparam int POS_W  = 6;
  localparam int CODE_W = 6;
  localparam int SYS_W  = 3;
  localparam int DISP_W = 6;
  localparam int SYNC_W = 4;
  localparam int DET_W  = 4;

  typedef enum logic [2:0] {
    CMD_ADDR  = 3'd0,
    CMD_CHAR  = 3'd1,
    CMD_VERT  = 3'd2,
    CMD_HORIZ = 3'd3,
    CMD_DISP  = 3'd4,
    CMD_SYNC  = 3'd5,
    CMD_RSV6  = 3'd6,
    CMD_RSV7  = 3'd7
  } cmd_e;

  // strobes from the serial control to the register datapath
  typedef struct packed {
    logic       wrChar;
    logic       ldFirst;
    logic       ldSecond;
    cmd_e       cmd;
    logic [6:0] data;
  } osd_strobe_t;
endpackage

// File: rtl/osd_serial_ctrl.sv
module osd_serial_ctrl
  import osd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  output osd_strobe_t strb
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [1:0] csSync;
  logic [2:0] sclkSync;
  logic [1:0] sdiSync;
  logic       csPrev;
  logic [BYTE_W-2:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  cmd_e       heldCode;

  logic csHigh, csRise, sclkRise, byteDone;
  logic [BYTE_W-1:0] newByte;
  logic streaming;

  assign csHigh    = csSync[1];
  assign csRise    = csHigh & ~csPrev;
  assign sclkRise  = sclkSync[1] & ~sclkSync[2];
  assign byteDone  = ~csHigh & sclkRise & (bitCnt == CNT_W'(BYTE_W - 1));
  assign newByte   = {shReg, sdiSync[1]};
  assign streaming = (heldCode == CMD_CHAR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sclkSync <= '0;
      sdiSync  <= '0;
      csPrev   <= 1'b1;
    end else begin
      csSync   <= {csSync[0], csN};
      sclkSync <= {sclkSync[1:0], sclk};
      sdiSync  <= {sdiSync[0], sdi};
      csPrev   <= csHigh;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else if (csHigh) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      shReg  <= newByte[BYTE_W-2:0];
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldCode <= CMD_ADDR;
    end else if (csRise) begin
      heldCode <= CMD_ADDR;
    end else if (byteDone && !streaming && newByte[7]) begin
      if (cmd_e'(newByte[6:4]) == CMD_DISP && newByte[0])
        heldCode <= CMD_ADDR;
      else
        heldCode <= cmd_e'(newByte[6:4]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb <= '0;
    end else begin
      strb.wrChar   <= byteDone & streaming;
      strb.ldFirst  <= byteDone & ~streaming & newByte[7];
      strb.ldSecond <= byteDone & ~streaming & ~newByte[7];
      strb.cmd      <= (newByte[7] && !streaming) ? cmd_e'(newByte[6:4]) : heldCode;
      strb.data     <= newByte[6:0];
    end
  end

  // R7: chip-select rise restores the address command
  assert_held_revert_R7: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (heldCode == CMD_ADDR));

  // R2: nothing is issued from a word cut short by chip select
  assert_no_word_after_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> !(strb.wrChar || strb.ldFirst || strb.ldSecond));
endmodule

// File: rtl/osd_reg_datapath.sv
module osd_reg_datapath
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 24,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  osd_strobe_t                  strb,
  output logic                         memWe,
  output logic [ROW_W-1:0]             memRow,
  output logic [COL_W-1:0]             memCol,
  output logic [CODE_W-1:0]            memCode,
  output logic                         memFlash,
  output logic [1:0][SIZE_W-1:0]       axisSize,
  output logic [1:0][POS_W-1:0]        axisStart,
  output logic [SYS_W-1:0]             sysCtrl,
  output logic [DISP_W-1:0]            dispCtrl,
  output logic [SYNC_W-1:0]            syncCtrl,
  output logic [DET_W-1:0]             detectSel
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] rowPtr;
  logic [COL_W-1:0] colPtr;
  logic softClr, detOk;

  assign softClr = strb.ldFirst && strb.cmd == CMD_DISP && strb.data[0];
  assign detOk   = ((strb.data[DET_W-1:0] & (strb.data[DET_W-1:0] - 1'b1)) == '0);

  // vertical and horizontal share one register layout
  for (genvar ax = 0; ax < 2; ax++) begin : gAxis
    localparam cmd_e AX_CMD = (ax == 0) ? CMD_VERT : CMD_HORIZ;
    logic [SIZE_W-1:0] sizeQ;
    logic [POS_W-1:0]  startQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sizeQ  <= '0;
        startQ <= '0;
      end else if (softClr) begin
        sizeQ  <= '0;
        startQ <= '0;
      end else if (strb.cmd == AX_CMD) begin
        if (strb.ldFirst)  sizeQ  <= strb.data[SIZE_W-1:0];
        if (strb.ldSecond) startQ <= strb.data[POS_W-1:0];
      end
    end
    assign axisSize[ax]  = sizeQ;
    assign axisStart[ax] = startQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowPtr <= '0; colPtr <= '0;
      sysCtrl <= '0; dispCtrl <= '0; syncCtrl <= '0; detectSel <= '0;
    end else if (softClr) begin
      rowPtr <= '0; colPtr <= '0;
      sysCtrl <= '0; dispCtrl <= '0; syncCtrl <= '0; detectSel <= '0;
    end else if (strb.wrChar) begin
      if (colPtr == LAST_COL) begin
        colPtr <= '0;
        rowPtr <= (rowPtr >= LAST_ROW) ? '0 : rowPtr + 1'b1;
      end else begin
        colPtr <= colPtr + 1'b1;
      end
    end else if (strb.ldFirst) begin
      unique case (strb.cmd)
        CMD_ADDR: rowPtr   <= strb.data[ROW_W-1:0];
        CMD_DISP: sysCtrl  <= strb.data[SYS_W:1];
        CMD_SYNC: syncCtrl <= strb.data[SYNC_W-1:0];
        default: ;
      endcase
    end else if (strb.ldSecond) begin
      unique case (strb.cmd)
        CMD_ADDR: colPtr   <= strb.data[COL_W-1:0];
        CMD_DISP: dispCtrl <= strb.data[DISP_W-1:0];
        CMD_SYNC: if (detOk) detectSel <= strb.data[DET_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWe <= 1'b0; memRow <= '0; memCol <= '0; memCode <= '0; memFlash <= 1'b0;
    end else begin
      memWe <= strb.wrChar;
      if (strb.wrChar) begin
        memRow   <= rowPtr;
        memCol   <= colPtr;
        memCode  <= strb.data[CODE_W-1:0];
        memFlash <= strb.data[6];
      end
    end
  end

  // R5: a character strobe lands on the write port at the pointer
  assert_char_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrChar |=> (memWe && memCol == $past(colPtr) && memRow == $past(rowPtr)));

  // R6: the last column wraps to zero
  assert_col_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrChar && colPtr == LAST_COL) |=> (colPtr == '0));

  // R10: detection count only ever takes one-hot or zero
  assert_detect_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(detectSel) |-> $onehot0(detectSel));

  // R11: soft reset clears the registers
  assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    softClr |=> (dispCtrl == '0 && sysCtrl == '0 && syncCtrl == '0 && rowPtr == '0 && axisStart == '0));
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 24,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  output logic              memWe,
  output logic [ROW_W-1:0]  memRow,
  output logic [COL_W-1:0]  memCol,
  output logic [CODE_W-1:0] memCode,
  output logic              memFlash,
  output logic [SIZE_W-1:0] sizeVert,
  output logic [POS_W-1:0]  vStart,
  output logic [SIZE_W-1:0] sizeHoriz,
  output logic [POS_W-1:0]  hStart,
  output logic [SYS_W-1:0]  sysCtrl,
  output logic [DISP_W-1:0] dispCtrl,
  output logic [SYNC_W-1:0] syncCtrl,
  output logic [DET_W-1:0]  detectSel
);
  osd_strobe_t strb;
  logic [1:0][SIZE_W-1:0] axisSize;
  logic [1:0][POS_W-1:0]  axisStart;

  osd_serial_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi), .strb(strb)
  );

  osd_reg_datapath #(.ROWS(ROWS), .COLS(COLS)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .memWe(memWe), .memRow(memRow), .memCol(memCol), .memCode(memCode), .memFlash(memFlash),
    .axisSize(axisSize), .axisStart(axisStart),
    .sysCtrl(sysCtrl), .dispCtrl(dispCtrl), .syncCtrl(syncCtrl), .detectSel(detectSel)
  );

  assign sizeVert  = axisSize[0];
  assign vStart    = axisStart[0];
  assign sizeHoriz = axisSize[1];
  assign hStart    = axisStart[1];
endmodule

// File: tb/tb_osd_cmd_decoder.sv
module tb_osd_cmd_decoder;
  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic memWe, memFlash;
  logic [3:0] memRow, sizeVert, sizeHoriz, syncCtrl, detectSel;
  logic [4:0] memCol;
  logic [5:0] memCode, vStart, hStart, dispCtrl;
  logic [2:0] sysCtrl;

  int nChecks = 0, nFail = 0, wrCount = 0;
  logic [15:0] wrLog [32];

  always #4 clk = ~clk;

  osd_cmd_decoder dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .memWe(memWe), .memRow(memRow), .memCol(memCol), .memCode(memCode), .memFlash(memFlash),
    .sizeVert(sizeVert), .vStart(vStart), .sizeHoriz(sizeHoriz), .hStart(hStart),
    .sysCtrl(sysCtrl), .dispCtrl(dispCtrl), .syncCtrl(syncCtrl), .detectSel(detectSel)
  );

  // {b1, b2, sizeVert, vStart, sizeHoriz, hStart, sysCtrl, dispCtrl, syncCtrl, detectSel}
  localparam logic [52:0] VECS [8] = '{
    {8'hA6, 8'h2B, 4'h6, 6'h2B, 4'h0, 6'h00, 3'h0, 6'h00, 4'h0, 4'h0},
    {8'hB9, 8'h15, 4'h6, 6'h2B, 4'h9, 6'h15, 3'h0, 6'h00, 4'h0, 4'h0},
    {8'hCE, 8'h2D, 4'h6, 6'h2B, 4'h9, 6'h15, 3'h7, 6'h2D, 4'h0, 4'h0},
    {8'hDD, 8'h04, 4'h6, 6'h2B, 4'h9, 6'h15, 3'h7, 6'h2D, 4'hD, 4'h4},
    {8'hD2, 8'h05, 4'h6, 6'h2B, 4'h9, 6'h15, 3'h7, 6'h2D, 4'h2, 4'h4},
    {8'hE0, 8'h3F, 4'h6, 6'h2B, 4'h9, 6'h15, 3'h7, 6'h2D, 4'h2, 4'h4},
    {8'hA1, 8'h00, 4'h1, 6'h00, 4'h9, 6'h15, 3'h7, 6'h2D, 4'h2, 4'h4},
    {8'hD0, 8'h00, 4'h1, 6'h00, 4'h9, 6'h15, 3'h7, 6'h2D, 4'h0, 4'h0}
  };

  function automatic logic [36:0] cfgNow();
    return {sizeVert, vStart, sizeHoriz, hStart, sysCtrl, dispCtrl, syncCtrl, detectSel};
  endfunction

  always @(negedge clk) begin
    if (memWe === 1'b1) begin
      if (wrCount < 32) wrLog[wrCount] = {memRow, memCol, memCode, memFlash};
      wrCount++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkWrite(input string req, input int idx, input logic [3:0] r,
                            input logic [4:0] c, input logic [5:0] code, input logic fl);
    check(req, (idx < 32) ? 64'(wrLog[idx]) : 64'hDEAD, 64'({r, c, code, fl}));
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startFrame();
    waitClk(1); csN = 1'b0; waitClk(4);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i]; waitClk(4); sclk = 1'b1; waitClk(4); sclk = 1'b0;
    end
  endtask

  task automatic endFrame();
    waitClk(4); csN = 1'b1; waitClk(12);
  endtask

  // final bit followed one clock later by chip-select rise
  task automatic sendLastQuick(input logic [7:0] b);
    sendBits(b, 7);
    sdi = b[0]; waitClk(4); sclk = 1'b1;
    waitClk(1); csN = 1'b1;
    waitClk(3); sclk = 1'b0; waitClk(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    waitClk(5);
    // R12: reset state
    check("R12 config after reset", 64'(cfgNow()), 64'h0);
    check("R12 memWe after reset", 64'(memWe), 64'h0);
    rstN = 1'b1; waitClk(4);

    // table: R1 R3 R8 R9 R10
    for (int v = 0; v < 8; v++) begin
      startFrame(); sendBits(VECS[v][52:45], 8); sendBits(VECS[v][44:37], 8); endFrame();
      check($sformatf("R1 R3 R8 R9 R10 vector %0d", v), 64'(cfgNow()), 64'(VECS[v][36:0]));
    end

    // R3: several second bytes under one held code
    startFrame(); sendBits(8'hA5, 8); sendBits(8'h10, 8); sendBits(8'h22, 8); endFrame();
    check("R3 held vertical size", 64'(sizeVert), 64'h5);
    check("R3 held vertical start", 64'(vStart), 64'h22);

    // R4 R5 R6: address then streaming, bit7-set byte written as data
    startFrame();
    sendBits(8'h83, 8); sendBits(8'h16, 8); sendBits(8'h90, 8);
    sendBits(8'h41, 8); sendBits(8'h85, 8); sendBits(8'h3F, 8);
    endFrame();
    check("R5 write count", 64'(wrCount), 64'd3);
    checkWrite("R4 R5 first write", 0, 4'd3, 5'd22, 6'h01, 1'b1);
    checkWrite("R5 byte with bit7 set", 1, 4'd3, 5'd23, 6'h05, 1'b0);
    checkWrite("R6 column wrap", 2, 4'd4, 5'd0, 6'h3F, 1'b0);

    // R6 row wrap; R7 last write coinciding with chip-select rise
    startFrame();
    sendBits(8'h89, 8); sendBits(8'h17, 8); sendBits(8'h90, 8); sendBits(8'h2A, 8);
    sendLastQuick(8'h2B);
    checkWrite("R6 row 9 col 23", 3, 4'd9, 5'd23, 6'h2A, 1'b0);
    checkWrite("R7 write at cs rise after row wrap R6", 4, 4'd0, 5'd0, 6'h2B, 1'b0);
    startFrame(); sendBits(8'h07, 8); endFrame();
    check("R7 lone byte is not a character", 64'(wrCount), 64'd5);
    startFrame(); sendBits(8'h90, 8); sendBits(8'h12, 8); endFrame();
    checkWrite("R7 lone byte set column", 5, 4'd0, 5'd7, 6'h12, 1'b0);

    // R2: partial word discarded
    startFrame(); sendBits(8'hFF, 5); endFrame();
    startFrame();
    sendBits(8'h84, 8); sendBits(8'h01, 8); sendBits(8'h90, 8); sendBits(8'h20, 8);
    endFrame();
    checkWrite("R2 frame after partial word", 6, 4'd4, 5'd1, 6'h20, 1'b0);

    // R11: soft reset
    startFrame();
    sendBits(8'hCF, 8); sendBits(8'h0C, 8); sendBits(8'h90, 8); sendBits(8'h00, 8);
    endFrame();
    check("R11 soft reset clears config", 64'(cfgNow()), 64'h0);
    checkWrite("R11 soft reset clears pointer", 7, 4'd0, 5'd12, 6'h00, 1'b0);

    // R11: hardware reset
    startFrame(); sendBits(8'hA6, 8); sendBits(8'h2B, 8); endFrame();
    check("R11 setup before hardware reset", 64'(vStart), 64'h2B);
    rstN = 1'b0; waitClk(3);
    check("R11 hardware reset clears config", 64'(cfgNow()), 64'h0);
    rstN = 1'b1; waitClk(4);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule